// File: doc/BRIEF.md
# Masked Interrupt Aggregation Controller

This block gathers 32 external interrupt request lines into a single processor interrupt. Each line is synchronised, normalised to an active-high sense by a per-line polarity bit, and then either tracked directly (level mode) or latched on its rising normalised edge (edge mode). The resulting pending bits are filtered by a board-specific set of valid lines and by a software enable mask. Any surviving request drives a registered interrupt output.

Software reaches six registers through a single-cycle port made of address, write enable, write data and combinational read data. Line 31 is reserved for the summary output of a cascaded secondary controller and is always treated as active high. Lines 20 to 30 have no connection and can never appear as pending. Latched edge requests are dismissed by writing a 1 to the line's bit of the clear register and then writing 0 back. A separate register emits a one-cycle system reset pulse, but only when one specific key value is written to it.

Top module: `irq_gather`

## Requirements
- R1: After reset the enable, trigger-mode, polarity and clear registers read 0, the interrupt output is low and the reset pulse output is low.
- R2: Register addresses are 0 enable mask, 1 trigger mode, 2 polarity, 3 clear, 4 request summary, 5 reset key. Reads of addresses 0 to 3 return the last value written, and a read of address 5 returns 0.
- R3: Polarity bit 1 makes a line active high and polarity bit 0 makes it active low. Line 31 is active high whatever its polarity bit holds.
- R4: A line in level mode (trigger bit 0) shows as pending in the summary (address 4) while its normalised input is active. The summary reflects an input change within 4 clock cycles.
- R5: A line in edge mode (trigger bit 1) becomes pending on a rising edge of its normalised input and stays pending after the input returns inactive.
- R6: While a line's clear bit is 1, its edge-mode pending bit is held at 0, even if new edges arrive. After the clear bit returns to 0, the line stays not pending until a new rising edge.
- R7: Summary bits 20 to 30, and any bit outside the valid-lines parameter, always read 0.
- R8: The interrupt output is registered and is high exactly when the previous cycle's summary AND enable mask is non-zero. A pending line with a mask bit of 0 does not raise it.
- R9: A write to the summary address changes nothing that can be read back.
- R10: A write of 0x0000DEAD to address 5 raises the reset pulse output for exactly one cycle. A write of any other value to address 5 leaves the reset pulse output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 32 | External interrupt request lines |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Register write enable |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | 1 | Aggregated interrupt to the processor |
| sys_rst_o | output | 1 | One-cycle system reset pulse |

## Verification
A pending bit that is stuck or wrongly latched shows up in the summary read within four cycles of the input change. It shows up on the interrupt pin one cycle after that. A clear register that fails to hold a latched line low is exposed by reading the summary while edges arrive under an active clear. The same read after the clear is released exposes one that fails to release the line. A wrong key comparison shows up on the reset pulse pin in the cycle right after the write.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_MASK = 3'd0,
    SEL_TRIG = 3'd1,
    SEL_POL  = 3'd2,
    SEL_CLR  = 3'd3,
    SEL_SUM  = 3'd4,
    SEL_RST  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/irq_gather_rstsync.sv
module irq_gather_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/irq_gather_sync.sv
module irq_gather_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/irq_gather_line.sv
module irq_gather_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic pol_high_i,
  input  logic trig_edge_i,
  input  logic clr_i,
  output logic pend_o
);
  logic norm;
  logic prev_q;
  logic pend_q;
  logic pend_d;
  logic rise;

  // normalise to active-high
  assign norm = pol_high_i ? sync_i : ~sync_i;
  assign rise = norm & ~prev_q;

  always_comb begin
    if (trig_edge_i) begin
      if (clr_i) pend_d = 1'b0;
      else       pend_d = pend_q | rise;
    end else begin
      pend_d = norm;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= norm;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_gather_regs.sv
module irq_gather_regs
  import irq_gather_pkg::*;
#(
  parameter int unsigned       WIDTH   = 32,
  parameter logic [WIDTH-1:0]  RST_KEY = 32'h0000_DEAD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [WIDTH-1:0]  wr_data_i,
  input  logic [WIDTH-1:0]  summary_i,
  output logic [WIDTH-1:0]  rd_data_o,
  output logic [WIDTH-1:0]  mask_o,
  output logic [WIDTH-1:0]  trig_o,
  output logic [WIDTH-1:0]  pol_o,
  output logic [WIDTH-1:0]  clr_o,
  output logic              sys_rst_o
);
  logic [WIDTH-1:0] mask_q, trig_q, pol_q, clr_q;
  logic             mask_en, trig_en, pol_en, clr_en;
  logic             pulse_d, pulse_q;

  always_comb begin
    mask_en = wr_en_i && (addr_i == SEL_MASK);
    trig_en = wr_en_i && (addr_i == SEL_TRIG);
    pol_en  = wr_en_i && (addr_i == SEL_POL);
    clr_en  = wr_en_i && (addr_i == SEL_CLR);
    pulse_d = wr_en_i && (addr_i == SEL_RST) && (wr_data_i == RST_KEY);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      trig_q  <= '0;
      pol_q   <= '0;
      clr_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (mask_en) mask_q <= wr_data_i;
      if (trig_en) trig_q <= wr_data_i;
      if (pol_en)  pol_q  <= wr_data_i;
      if (clr_en)  clr_q  <= wr_data_i;
      pulse_q <= pulse_d;
    end
  end

  always_comb begin
    unique case (addr_i)
      SEL_MASK: rd_data_o = mask_q;
      SEL_TRIG: rd_data_o = trig_q;
      SEL_POL:  rd_data_o = pol_q;
      SEL_CLR:  rd_data_o = clr_q;
      SEL_SUM:  rd_data_o = summary_i;
      default:  rd_data_o = '0;
    endcase
  end

  assign mask_o    = mask_q;
  assign trig_o    = trig_q;
  assign pol_o     = pol_q;
  assign clr_o     = clr_q;
  assign sys_rst_o = pulse_q;
endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irq_gather_pkg::*;
#(
  parameter int unsigned      NUM_LINES    = 32,
  parameter logic [31:0]      VALID_LINES  = 32'h800F_FFFF,
  parameter int unsigned      CASCADE_LINE = 31,
  parameter int unsigned      DEAD_LO      = 20,
  parameter int unsigned      DEAD_HI      = 30,
  parameter logic [31:0]      RST_KEY      = 32'h0000_DEAD
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LINES-1:0]  req_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_en_i,
  input  logic [NUM_LINES-1:0]  wr_data_i,
  output logic [NUM_LINES-1:0]  rd_data_o,
  output logic                  irq_o,
  output logic                  sys_rst_o
);
  function automatic logic [NUM_LINES-1:0] range_mask(int unsigned lo, int unsigned hi);
    logic [NUM_LINES-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < NUM_LINES; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [NUM_LINES-1:0] DEAD_MASK  = range_mask(DEAD_LO, DEAD_HI);
  localparam logic [NUM_LINES-1:0] FORCE_HIGH = range_mask(CASCADE_LINE, CASCADE_LINE);
  localparam logic [NUM_LINES-1:0] VALID_EFF  = VALID_LINES[NUM_LINES-1:0] & ~DEAD_MASK;

  logic                 rst_sync_n;
  logic [NUM_LINES-1:0] sync_w;
  logic [NUM_LINES-1:0] pend_w;
  logic [NUM_LINES-1:0] summary_w;
  logic [NUM_LINES-1:0] mask_w, trig_w, pol_w, clr_w, pol_eff;
  logic                 irq_d, irq_q;

  irq_gather_rstsync #(.STAGES(2)) u_rstsync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  irq_gather_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .async_i (req_i),
    .sync_o  (sync_w)
  );

  assign pol_eff = pol_w | FORCE_HIGH;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_gather_line u_line (
      .clk_i       (clk_i),
      .rst_ni      (rst_sync_n),
      .sync_i      (sync_w[g]),
      .pol_high_i  (pol_eff[g]),
      .trig_edge_i (trig_w[g]),
      .clr_i       (clr_w[g]),
      .pend_o      (pend_w[g])
    );
  end

  assign summary_w = pend_w & VALID_EFF;

  irq_gather_regs #(.WIDTH(NUM_LINES), .RST_KEY(RST_KEY[NUM_LINES-1:0])) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .summary_i (summary_w),
    .rd_data_o (rd_data_o),
    .mask_o    (mask_w),
    .trig_o    (trig_w),
    .pol_o     (pol_w),
    .clr_o     (clr_w),
    .sys_rst_o (sys_rst_o)
  );

  always_comb begin
    irq_d = |(summary_w & mask_w);
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk
  import irq_gather_pkg::*;
#(
  parameter int unsigned          N         = 32,
  parameter logic [N-1:0]         DEAD_MASK = '0,
  parameter logic [N-1:0]         KEY       = '0
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [N-1:0]      wr_data_i,
  input logic [N-1:0]      rd_data_o,
  input logic              irq_o,
  input logic              sys_rst_o,
  input logic [N-1:0]      mask_q,
  input logic [N-1:0]      trig_q,
  input logic [N-1:0]      clr_q,
  input logic [N-1:0]      summary
);
  a_r10_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_n)
    sys_rst_o |=> !sys_rst_o);

  a_r10_key_only: assert property (@(posedge clk_i) disable iff (!rst_n)
    sys_rst_o |-> $past(wr_en_i && (addr_i == SEL_RST) && (wr_data_i == KEY)));

  a_r8_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|(summary & mask_q)) |=> irq_o);

  a_r8_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(|(summary & mask_q)) |=> !irq_o);

  a_r7_dead_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    (addr_i == SEL_SUM) |-> ((rd_data_o & DEAD_MASK) == '0));

  a_r6_clear_holds: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((trig_q & clr_q) != '0) |=> ((summary & $past(trig_q & clr_q)) == '0));
endmodule

bind irq_gather irq_gather_chk #(
  .N         (NUM_LINES),
  .DEAD_MASK (DEAD_MASK),
  .KEY       (RST_KEY[NUM_LINES-1:0])
) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_sync_n),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o),
  .sys_rst_o (sys_rst_o),
  .mask_q    (mask_w),
  .trig_q    (trig_w),
  .clr_q     (clr_w),
  .summary   (summary_w)
);

// File: tb/irq_gather_bench.sv
module irq_gather_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;

  localparam logic [2:0] A_MASK = 3'd0, A_TRIG = 3'd1, A_POL = 3'd2,
                         A_CLR = 3'd3, A_SUM = 3'd4, A_RST = 3'd5;

  typedef struct {
    int          kind;   // 0 read data, 1 irq pin, 2 reset pulse pin
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] req;
  logic [2:0]  addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  logic        sys_rst;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_gather u_irq_gather (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .req_i     (req),
    .addr_i    (addr),
    .wr_en_i   (we),
    .wr_data_i (wdata),
    .rd_data_o (rdata),
    .irq_o     (irq),
    .sys_rst_o (sys_rst)
  );

  // monitor: pops one expectation per cycle, away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = exp_q.pop_front();
      case (it.kind)
        0:       act = rdata;
        1:       act = {31'b0, irq};
        default: act = {31'b0, sys_rst};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    step();
    we = 1'b0;
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    addr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    step();
  endtask

  task automatic expect_pin(input int k, input logic e, input string tag);
    item_t it;
    it.kind = k; it.exp = {31'b0, e}; it.tag = tag;
    exp_q.push_back(it);
    step();
  endtask

  initial begin
    rst_n = 1'b0; req = '0; addr = '0; we = 1'b0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(5);

    // R1 reset state
    expect_rd(A_MASK, 32'h0, "R1 mask after reset");
    expect_rd(A_TRIG, 32'h0, "R1 trigger after reset");
    expect_rd(A_POL,  32'h0, "R1 polarity after reset");
    expect_rd(A_CLR,  32'h0, "R1 clear after reset");
    expect_pin(1, 1'b0, "R1 irq after reset");
    expect_pin(2, 1'b0, "R1 reset pulse after reset");
    // R3 active-low lines with low inputs pend, line 31 stays active high; R7 dead lines hidden
    expect_rd(A_SUM, 32'h000F_FFFF, "R3 R7 summary with active-low defaults");

    wr(A_POL, 32'hFFFF_FFFF);
    idle(4);
    expect_rd(A_SUM, 32'h0, "R3 all active high, inputs low");
    expect_rd(A_POL, 32'hFFFF_FFFF, "R2 polarity readback");

    req = 32'hFFFF_FFFF;
    idle(4);
    expect_rd(A_SUM, 32'h800F_FFFF, "R4 R7 level lines follow input");
    expect_pin(1, 1'b0, "R8 irq low with mask zero");

    wr(A_MASK, 32'h0000_0005);
    idle(3);
    expect_pin(1, 1'b1, "R8 irq with enabled pending line");
    expect_rd(A_MASK, 32'h0000_0005, "R2 mask readback");

    wr(A_SUM, 32'h0000_1234);
    expect_rd(A_SUM, 32'h800F_FFFF, "R9 summary write ignored");
    expect_rd(A_MASK, 32'h0000_0005, "R9 mask untouched by summary write");

    wr(A_POL, 32'h0);
    idle(4);
    expect_rd(A_SUM, 32'h8000_0000, "R3 line 31 ignores polarity bit");
    expect_pin(1, 1'b0, "R8 pending line 31 masked off");

    wr(A_POL, 32'hFFFF_FFFF);
    req = 32'h8000_0000;
    idle(4);
    expect_rd(A_SUM, 32'h8000_0000, "R4 level line drops with input");

    wr(A_TRIG, 32'h0000_0001);
    expect_rd(A_TRIG, 32'h0000_0001, "R2 trigger readback");
    req = 32'h8000_0001;
    idle(4);
    expect_rd(A_SUM, 32'h8000_0001, "R5 edge latched");
    req = 32'h8000_0000;
    idle(4);
    expect_rd(A_SUM, 32'h8000_0001, "R5 edge held after input drop");
    expect_pin(1, 1'b1, "R8 irq from latched edge");

    wr(A_CLR, 32'h0000_0001);
    idle(2);
    expect_rd(A_SUM, 32'h8000_0000, "R6 clear forces pending low");
    expect_rd(A_CLR, 32'h0000_0001, "R2 clear readback");
    req = 32'h8000_0001;
    idle(4);
    expect_rd(A_SUM, 32'h8000_0000, "R6 edge blocked while clear held");
    wr(A_CLR, 32'h0);
    idle(3);
    expect_rd(A_SUM, 32'h8000_0000, "R6 no relatch after clear release");
    expect_pin(1, 1'b0, "R8 irq low after clear");
    req = 32'h8000_0000;
    idle(4);
    req = 32'h8000_0001;
    idle(4);
    expect_rd(A_SUM, 32'h8000_0001, "R5 new edge latches again");

    wr(A_RST, 32'h0000_DEAE);
    expect_pin(2, 1'b0, "R10 wrong key no pulse");
    expect_pin(2, 1'b0, "R10 wrong key no pulse later");
    wr(A_RST, 32'h0000_DEAD);
    expect_pin(2, 1'b1, "R10 key raises pulse");
    expect_pin(2, 1'b0, "R10 pulse lasts one cycle");
    expect_rd(A_RST, 32'h0, "R2 reset register reads zero");

    idle(2);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < WDOG_CYCLES; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1-flow actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule